// File: doc/BRIEF.md
# Fast Reference Clock Loss Detector

This block watches the reference clock that a downstream phase-locked loop is currently tracking. It samples that clock with a faster system clock. When roughly two expected reference periods pass with no rising edge, it raises a holdover request. The loop uses this request to freeze its frequency and stay clear of the disturbance. When reference edges return, the request drops and the loop resumes tracking. The caller programs the expected reference period in system clock cycles. A fixed margin of extra cycles sits on top of twice that period.

Each loss event also sets a sticky status bit at bit 6 of an eight-bit interrupt status word. Software clears the bit by writing a one to that position. The interrupt line is the status bit gated by an interrupt mask. A separate pin copy of the bit ignores the mask and has its own enable, so board logic can act on a reference failure without software.

Top module: `fcl_loss_detector`

## Requirements
- R1: After a rising reference edge with no later rising edge, `holdover_req` rises exactly at the (2·`period_cfg` + MARGIN + 4)th rising edge of `clk_sys`. Two of those edges come from the synchronizer and one from edge detection.
- R2: While successive rising reference edges are at most 2·`period_cfg` + MARGIN system cycles apart, `holdover_req` stays low. This holds even when a single reference cycle is missing.
- R3: Once `holdover_req` is high, a new rising reference edge drops it at the third rising edge of `clk_sys` after that reference edge.
- R4: The sticky status bit `loss_sts` (bit 6 of the status word) sets one system cycle after `holdover_req` rises. It stays set after `holdover_req` falls.
- R5: A status write (`sts_wr` high) with `sts_wdata[6]` = 1 clears `loss_sts` at the next clock edge. A write with `sts_wdata[6]` = 0 leaves it unchanged.
- R6: When a loss event and a clearing write land on the same clock edge, `loss_sts` ends up set.
- R7: `irq` equals `loss_sts` AND NOT `irq_mask`.
- R8: `loss_pin` equals `loss_sts` AND `mirror_en`, whatever the state of `irq_mask`.
- R9: While `rst_n` is low, `holdover_req`, `loss_sts`, `irq` and `loss_pin` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock, faster than the reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Selected reference clock, asynchronous |
| period_cfg | input | CNT_W | Expected reference period in system cycles |
| mirror_en | input | 1 | Enables the pin copy of the status bit |
| irq_mask | input | 1 | Masks the status bit from `irq` |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 8 | Status write data; a one in bit 6 clears the loss bit |
| holdover_req | output | 1 | Freeze request to the downstream loop |
| loss_sts | output | 1 | Sticky loss status bit (bit 6) |
| irq | output | 1 | Masked interrupt |
| loss_pin | output | 1 | Unmasked pin copy of the status bit |

## Verification
The bench builds the block with CNT_W = 8 and MARGIN = 3. With these values, reference periods of 8 to 24 system cycles give detection windows under sixty cycles. Many loss and recovery sequences therefore fit in a short run. The short counter also keeps the saturating count and the limit arithmetic close to their widths. With these settings, the exact edge at which the request rises can be checked against a count the bench derives from the period. The same applies to the edge at which the request drops. The clear and loss event can also be aligned deliberately onto one clock edge.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
    localparam int STS_W    = 8;
    localparam int LOSS_BIT = 6;
endpackage

// File: rtl/fcl_ref_sync.sv
module fcl_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic edge_p
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = ref_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_p = st_q.chain[STAGES-1] & ~st_q.prev;

    initial begin
        if (STAGES < 2) $error("fcl_ref_sync needs at least two stages");
    end
endmodule

// File: rtl/fcl_watchdog.sv
module fcl_watchdog #(
    parameter int CNT_W  = 16,
    parameter int MARGIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_p,
    input  logic [CNT_W-1:0] period_cfg,
    output logic             lost,
    output logic             loss_evt
);
    localparam int LIM_W = CNT_W + 2;
    localparam logic [LIM_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [LIM_W-1:0] cnt;
        logic             lost;
        logic             evt;
    } wd_st_t;

    wd_st_t st_d, st_q;
    logic [LIM_W-1:0] limit;

    assign limit = (LIM_W'(period_cfg) << 1) + LIM_W'(MARGIN);

    always_comb begin
        st_d = st_q;
        if (edge_p) begin
            st_d.cnt  = '0;
            st_d.lost = 1'b0;
            st_d.evt  = 1'b0;
        end else begin
            st_d.cnt  = (st_q.cnt == CNT_MAX) ? CNT_MAX : st_q.cnt + 1'b1;
            st_d.lost = st_q.lost | (st_q.cnt >= limit);
            st_d.evt  = st_d.lost & ~st_q.lost;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lost     = st_q.lost;
    assign loss_evt = st_q.evt;

    // R3: a reference edge restarts the count and drops the loss flag
    a_r3_edge_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        edge_p |=> (st_q.cnt == '0) && !st_q.lost);

    // R1: the loss flag only rises once the count reached the limit
    a_r1_no_early_loss: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lost) |-> ($past(st_q.cnt) >= $past(limit)));

    // R4: the event pulse accompanies each rise of the loss flag
    a_r4_event_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lost) |-> st_q.evt);
endmodule

// File: rtl/fcl_status.sv
module fcl_status
    import fcl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loss_evt,
    input  logic             wr,
    input  logic [STS_W-1:0] wdata,
    output logic             sts
);
    typedef struct packed {
        logic bit_set;
    } sts_st_t;

    sts_st_t st_d, st_q;
    logic    clr;

    always_comb begin
        clr            = wr & wdata[LOSS_BIT];
        st_d.bit_set   = loss_evt | (st_q.bit_set & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts = st_q.bit_set;

    // R4: an event always leaves the bit set
    a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        loss_evt |=> sts);

    // R5: set bit holds unless a clearing write arrives
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sts && !(wr && wdata[LOSS_BIT])) |=> sts);

    // R5: a clearing write without an event empties the bit
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[LOSS_BIT] && !loss_evt) |=> !sts);
endmodule

// File: rtl/fcl_loss_detector.sv
module fcl_loss_detector
    import fcl_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int MARGIN      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_sys,
    input  logic             rst_n,
    input  logic             ref_clk,
    input  logic [CNT_W-1:0] period_cfg,
    input  logic             mirror_en,
    input  logic             irq_mask,
    input  logic             sts_wr,
    input  logic [STS_W-1:0] sts_wdata,
    output logic             holdover_req,
    output logic             loss_sts,
    output logic             irq,
    output logic             loss_pin
);
    logic ref_edge;
    logic lost;
    logic loss_evt;

    fcl_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk_sys),
        .rst_n  (rst_n),
        .ref_in (ref_clk),
        .edge_p (ref_edge)
    );

    fcl_watchdog #(.CNT_W(CNT_W), .MARGIN(MARGIN)) u_wd (
        .clk        (clk_sys),
        .rst_n      (rst_n),
        .edge_p     (ref_edge),
        .period_cfg (period_cfg),
        .lost       (lost),
        .loss_evt   (loss_evt)
    );

    fcl_status u_sts (
        .clk      (clk_sys),
        .rst_n    (rst_n),
        .loss_evt (loss_evt),
        .wr       (sts_wr),
        .wdata    (sts_wdata),
        .sts      (loss_sts)
    );

    assign holdover_req = lost;
    assign irq          = loss_sts & ~irq_mask;
    assign loss_pin     = loss_sts & mirror_en;

    // R7: masked interrupt never fires while masked
    a_r7_irq_masked: assert property (@(posedge clk_sys) disable iff (!rst_n)
        irq |-> (loss_sts && !irq_mask));

    // R8: pin copy only with the enable set, regardless of the mask
    a_r8_pin_enable: assert property (@(posedge clk_sys) disable iff (!rst_n)
        loss_pin |-> (loss_sts && mirror_en));

    // R4: status follows the rise of the freeze request one cycle later
    a_r4_status_follows: assert property (@(posedge clk_sys) disable iff (!rst_n)
        $rose(holdover_req) |=> loss_sts);
endmodule

// File: tb/sim_fcl_loss_detector.sv
module sim_fcl_loss_detector;
    localparam int CNT_W  = 8;
    localparam int MARGIN = 3;

    logic             clk_sys = 1'b0;
    logic             rst_n;
    logic             ref_clk;
    logic [CNT_W-1:0] period_cfg;
    logic             mirror_en;
    logic             irq_mask;
    logic             sts_wr;
    logic [7:0]       sts_wdata;
    logic             holdover_req, loss_sts, irq, loss_pin;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk_sys = ~clk_sys;

    fcl_loss_detector #(.CNT_W(CNT_W), .MARGIN(MARGIN)) u0 (
        .clk_sys(clk_sys), .rst_n(rst_n), .ref_clk(ref_clk),
        .period_cfg(period_cfg), .mirror_en(mirror_en), .irq_mask(irq_mask),
        .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .holdover_req(holdover_req), .loss_sts(loss_sts), .irq(irq), .loss_pin(loss_pin)
    );

    function automatic int loss_edge(int p);
        return 2 * p + MARGIN + 4;
    endfunction

    function automatic bit exp_irq(bit s, bit m);
        return s & ~m;
    endfunction

    function automatic bit exp_pin(bit s, bit en);
        return s & en;
    endfunction

    task automatic check(bit got, bit exp, string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk_sys);
    endtask

    task automatic run_ref(int p, int n);
        bit bad = 1'b0;
        for (int c = 0; c < n; c++) begin
            ref_clk = 1'b1;
            tick(p / 2);
            ref_clk = 1'b0;
            tick(p - p / 2);
            if (holdover_req) bad = 1'b1;
        end
        check(bad, 1'b0, "R2 request low while edges arrive");
    endtask

    task automatic write_sts(logic [7:0] d);
        sts_wdata = d;
        sts_wr    = 1'b1;
        tick(1);
        sts_wr    = 1'b0;
        sts_wdata = '0;
    endtask

    task automatic loss_test(int p, bit m, bit en, bit same_edge_clear);
        int l;
        period_cfg = CNT_W'(p);
        irq_mask   = m;
        mirror_en  = en;
        run_ref(p, 3);
        l = loss_edge(p);
        ref_clk = 1'b1;
        for (int j = 1; j <= l + 1; j++) begin
            tick(1);
            if (j == p / 2) ref_clk = 1'b0;
            if (j == l - 1) check(holdover_req, 1'b0, "R1 request low before limit");
            if (j == l)     check(holdover_req, 1'b1, "R1 request high at limit");
            if (same_edge_clear && j == l) begin
                sts_wr = 1'b1; sts_wdata = 8'h40;
            end
            if (j == l + 1) begin
                sts_wr = 1'b0; sts_wdata = '0;
                check(loss_sts, 1'b1, same_edge_clear ? "R6 set wins over clear" : "R4 status set");
                check(irq, exp_irq(1'b1, m), "R7 masked interrupt");
                check(loss_pin, exp_pin(1'b1, en), "R8 pin copy ignores mask");
            end
        end
        ref_clk = 1'b1;
        tick(2);
        check(holdover_req, 1'b1, "R3 request held two edges");
        tick(1);
        check(holdover_req, 1'b0, "R3 request released");
        check(loss_sts, 1'b1, "R4 status sticky after release");
        tick(p / 2 - 3);
        ref_clk = 1'b0;
        tick(p - p / 2);
        write_sts(8'hBF);
        check(loss_sts, 1'b1, "R5 write without bit 6 ignored");
        check(irq, exp_irq(1'b1, m), "R7 interrupt after ignored write");
        write_sts(8'h40);
        check(loss_sts, 1'b0, "R5 write with bit 6 clears");
        check(irq, 1'b0, "R7 interrupt cleared");
        check(loss_pin, 1'b0, "R8 pin cleared");
    endtask

    initial begin
        repeat (150000) @(posedge clk_sys);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        bit glitch_bad;
        seed = $urandom(32'd4242);
        rst_n = 1'b0; ref_clk = 1'b0; period_cfg = CNT_W'(10);
        mirror_en = 1'b1; irq_mask = 1'b0; sts_wr = 1'b0; sts_wdata = '0;
        tick(3);
        check(holdover_req, 1'b0, "R9 reset request");
        check(loss_sts, 1'b0, "R9 reset status");
        check(irq, 1'b0, "R9 reset irq");
        check(loss_pin, 1'b0, "R9 reset pin");
        rst_n = 1'b1;
        tick(2);

        // directed: shortest period, unmasked, pin on
        loss_test(8, 1'b0, 1'b1, 1'b0);
        // directed: masked interrupt with pin still mirrored
        loss_test(12, 1'b1, 1'b1, 1'b0);
        // directed: pin disabled
        loss_test(16, 1'b0, 1'b0, 1'b0);
        // directed: clear on the same edge as the event
        loss_test(10, 1'b0, 1'b1, 1'b1);

        // directed: one missing reference cycle must not trigger (R2)
        period_cfg = CNT_W'(10);
        run_ref(10, 3);
        glitch_bad = 1'b0;
        for (int j = 0; j < 10; j++) begin
            tick(1);
            if (holdover_req) glitch_bad = 1'b1;
        end
        run_ref(10, 2);
        check(glitch_bad, 1'b0, "R2 single missing cycle tolerated");
        check(loss_sts, 1'b0, "R2 no status from single missing cycle");

        for (int it = 0; it < 12; it++) begin
            int  p;
            bit  m, en, sc;
            p  = 8 + int'($urandom_range(16));
            m  = 1'($urandom_range(1));
            en = 1'($urandom_range(1));
            sc = ($urandom_range(3) == 0);
            loss_test(p, m, en, sc);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule